// File: doc/BRIEF.md
# Power-Up and PLL Reset Sequencer

This block derives two active-high internal resets from a free-running 25 MHz reference clock. The power-up reset is held high for a fixed window after the analog power-good indication comes up. The window is 10 ms, which is 250,000 reference cycles. The analog indication also clears the counter, so every startup begins from a known state. After the window expires, the power-up reset stays low until power-good drops again and re-arms it.

The PLL reset is a short pulse of a fixed length. It fires when the external active-low reset is asserted and ends after four reference cycles (160 ns), even if the external reset is still held low. This lets the PLL lock to its reference before the rest of the system leaves reset. The external reset is brought in through a multi-flop synchronizer, and its falling edge is detected on the synchronized value. The PLL reset is also held high for the whole power-up window, so the PLL starts out in reset.

Top module: `reset_sequencer`

## Requirements
- R1: While `pwr_ok` is low, `por_rst` and `pll_rst` are both high, without waiting for a clock edge.
- R2: After `pwr_ok` rises, `por_rst` stays high through exactly `POR_CYCLES` rising clock edges and falls on the edge numbered `POR_CYCLES` (default 250,000).
- R3: Once `por_rst` has fallen, it stays low for as long as `pwr_ok` stays high. Taking `pwr_ok` low and then high again starts a full new window.
- R4: `pll_rst` is high in every cycle in which `por_rst` is high.
- R5: A high-to-low change on `ext_rst_n` raises `pll_rst` on the third rising edge after the change: two edges for the synchronizer and one for the pulse register. `pll_rst` then stays high for exactly `PLL_CYCLES` cycles (default 4).
- R6: Holding `ext_rst_n` low produces one pulse only. `pll_rst` returns low while `ext_rst_n` is still low, and this also applies when `ext_rst_n` was already low as power-good came up.
- R7: A low-to-high change on `ext_rst_n` does not raise `pll_rst`.
- R8: A new falling edge on `ext_rst_n` that is detected while a pulse is running reloads the count. `pll_rst` then stays high until `PLL_CYCLES` cycles after the new edge is registered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running 25 MHz reference clock |
| pwr_ok | input | 1 | Analog power-good indication, active high; low clears all state asynchronously |
| ext_rst_n | input | 1 | External reset, active low, asynchronous to `clk` |
| por_rst | output | 1 | Power-up reset, active high |
| pll_rst | output | 1 | PLL reset, active high |

## Verification
The external reset is driven with four patterns. A single long low shows whether the pulse has the right start cycle and length, and whether it ends while the input is still low rather than following the input. A release to high checks that rising edges are ignored. A low-high-low pattern inside one pulse separates a reloading counter from one that ignores new edges or adds them up. Power-good is cycled twice, once with the external reset high and once with it held low, which separates a counter that saturates and re-arms from one that wraps, and shows that a reset already held at startup gives only one pulse.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  // Width needed to hold values 0..n inclusive.
  function automatic int cnt_bits(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // True when a zero-based count has reached the last cycle of an n-cycle window.
  function automatic logic at_last(input logic [31:0] cnt, input int n);
    return cnt == 32'(n - 1);
  endfunction

  // Next value of a down-counting pulse timer, reloaded on a trigger.
  function automatic logic [31:0] pulse_next(input logic [31:0] cur, input logic trig,
                                             input int len);
    if (trig) return 32'(len);
    if (cur != 32'd0) return cur - 32'd1;
    return cur;
  endfunction

  typedef enum logic {
    POR_COUNTING = 1'b0,
    POR_EXPIRED  = 1'b1
  } por_state_e;

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int  STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q[g] <= RST_VAL;
        else         chain_q[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q[g] <= RST_VAL;
        else         chain_q[g] <= chain_q[g-1];
      end
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rstseq_por_timer.sv
module rstseq_por_timer
  import rstseq_pkg::*;
#(
  parameter int POR_CYCLES = 250000
) (
  input  logic clk,
  input  logic arst_n,
  output logic por_rst,
  output logic done_evt
);
  localparam int CW = cnt_bits(POR_CYCLES);

  logic [CW-1:0] cnt_q;
  por_state_e    state_q;
  logic          last_cycle;

  assign last_cycle = (state_q == POR_COUNTING) && at_last(32'(cnt_q), POR_CYCLES);
  assign done_evt   = last_cycle;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q   <= '0;
      state_q <= POR_COUNTING;
    end else if (state_q == POR_COUNTING) begin
      if (last_cycle) state_q <= POR_EXPIRED;
      else            cnt_q   <= cnt_q + 1'b1;
    end
  end

  // The async clear forces the output high at once, not only on the next edge.
  assign por_rst = !arst_n || (state_q == POR_COUNTING);
endmodule

// File: rtl/rstseq_pll_pulse.sv
module rstseq_pll_pulse
  import rstseq_pkg::*;
#(
  parameter int PLL_CYCLES = 4
) (
  input  logic clk,
  input  logic arst_n,
  input  logic rst_sync_n,
  input  logic hold,
  output logic pll_rst,
  output logic fall_evt
);
  localparam int PW = cnt_bits(PLL_CYCLES);

  logic          prev_q;
  logic [PW-1:0] left_q;
  logic [31:0]   left_nx;

  assign fall_evt = prev_q && !rst_sync_n;
  assign left_nx  = pulse_next(32'(left_q), fall_evt, PLL_CYCLES);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      prev_q <= 1'b1;
      left_q <= '0;
    end else begin
      prev_q <= rst_sync_n;
      left_q <= left_nx[PW-1:0];
    end
  end

  assign pll_rst = hold || (left_q != '0);
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer #(
  parameter int POR_CYCLES  = 250000,
  parameter int PLL_CYCLES  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic pwr_ok,
  input  logic ext_rst_n,
  output logic por_rst,
  output logic pll_rst
);
  logic ext_sync_n;
  logic fall_evt;
  logic por_done_evt;

  rstseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .arst_n(pwr_ok), .d(ext_rst_n), .q(ext_sync_n)
  );

  rstseq_por_timer #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk(clk), .arst_n(pwr_ok), .por_rst(por_rst), .done_evt(por_done_evt)
  );

  rstseq_pll_pulse #(.PLL_CYCLES(PLL_CYCLES)) u_pll (
    .clk(clk), .arst_n(pwr_ok), .rst_sync_n(ext_sync_n), .hold(por_rst),
    .pll_rst(pll_rst), .fall_evt(fall_evt)
  );
endmodule

// File: rtl/rstseq_checker.sv
module rstseq_checker #(
  parameter int POR_CYCLES = 250000,
  parameter int PLL_CYCLES = 4
) (
  input logic clk,
  input logic pwr_ok,
  input logic por_rst,
  input logic pll_rst,
  input logic fall_evt,
  input logic por_done_evt
);
  localparam int AW = $clog2(POR_CYCLES + 2);
  localparam int PW = $clog2(PLL_CYCLES + 2);

  logic [AW-1:0] age_q;
  logic [PW-1:0] run_q;

  always_ff @(posedge clk or negedge pwr_ok) begin
    if (!pwr_ok) begin
      age_q <= '0;
      run_q <= '0;
    end else begin
      if (age_q != AW'(POR_CYCLES)) age_q <= age_q + 1'b1;
      if (fall_evt)            run_q <= PW'(PLL_CYCLES);
      else if (run_q != '0)    run_q <= run_q - 1'b1;
    end
  end

  always @(negedge clk) begin
    if (pwr_ok === 1'b0) begin
      p_async_hold_r1: assert (por_rst && pll_rst);
    end
  end

  p_por_window_r2: assert property (@(posedge clk) disable iff (!pwr_ok)
    $fell(por_rst) |-> age_q == AW'(POR_CYCLES));

  p_done_once_r2: assert property (@(posedge clk) disable iff (!pwr_ok)
    por_done_evt |=> !por_rst);

  p_por_stays_low_r3: assert property (@(posedge clk) disable iff (!pwr_ok)
    !por_rst |=> !por_rst);

  p_pll_covers_por_r4: assert property (@(posedge clk) disable iff (!pwr_ok)
    por_rst |-> pll_rst);

  p_pulse_start_r5: assert property (@(posedge clk) disable iff (!pwr_ok)
    fall_evt |=> pll_rst);

  p_pulse_body_r8: assert property (@(posedge clk) disable iff (!pwr_ok)
    (run_q != '0) |-> pll_rst);

  p_pulse_ends_r6: assert property (@(posedge clk) disable iff (!pwr_ok)
    (run_q == '0 && !por_rst) |-> !pll_rst);

  p_single_edge_r6: assert property (@(posedge clk) disable iff (!pwr_ok)
    fall_evt |=> !fall_evt);
endmodule

bind reset_sequencer rstseq_checker #(
  .POR_CYCLES(POR_CYCLES), .PLL_CYCLES(PLL_CYCLES)
) u_chk (
  .clk(clk), .pwr_ok(pwr_ok), .por_rst(por_rst), .pll_rst(pll_rst),
  .fall_evt(fall_evt), .por_done_evt(por_done_evt)
);

// File: tb/reset_sequencer_bench.sv
module reset_sequencer_bench;
  localparam int N = 40;
  localparam int L = 4;

  typedef struct {
    int    cyc;
    logic  por;
    logic  pll;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic pwr_ok = 1'b0;
  logic ext_rst_n = 1'b1;
  logic por_rst, pll_rst;
  int   cyc = 0;
  int   n_checks = 0;
  int   n_fail = 0;
  bit   done = 0;
  exp_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  reset_sequencer #(.POR_CYCLES(N), .PLL_CYCLES(L), .SYNC_STAGES(2)) u_reset_sequencer (
    .clk(clk), .pwr_ok(pwr_ok), .ext_rst_n(ext_rst_n),
    .por_rst(por_rst), .pll_rst(pll_rst)
  );

  // Monitor: compare outputs at the falling edge against queued expectations.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      e = q.pop_front();
      n_checks++;
      if (e.cyc < cyc) begin
        n_fail++;
        $display("FAIL %s: expectation for cycle %0d missed (now %0d)", e.tag, e.cyc, cyc);
      end else if (por_rst !== e.por || pll_rst !== e.pll) begin
        n_fail++;
        $display("FAIL %s cyc %0d: por=%b pll=%b expected por=%b pll=%b",
                 e.tag, cyc, por_rst, pll_rst, e.por, e.pll);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_span(input int c0, input int c1, input logic p, input logic l,
                             input string tag);
    for (int c = c0; c <= c1; c++) q.push_back('{c, p, l, tag});
  endtask

  task automatic drain();
    while (q.size() > 0) step();
  endtask

  task automatic power_up(input logic ext_level, input string tag);
    int c;
    pwr_ok = 1'b0;
    ext_rst_n = ext_level;
    #0.5;
    n_checks++;  // R1: asynchronous effect before any edge
    if (por_rst !== 1'b1 || pll_rst !== 1'b1) begin
      n_fail++;
      $display("FAIL R1: por=%b pll=%b expected por=1 pll=1 with pwr_ok low", por_rst, pll_rst);
    end
    step();
    expect_span(cyc, cyc + 2, 1'b1, 1'b1, "R1");
    drain();
    step();
    pwr_ok = 1'b1;
    c = cyc;
    expect_span(c, c + N - 1, 1'b1, 1'b1, {tag, " R2/R4 window"});
    expect_span(c + N, c + N + 5, 1'b0, 1'b0, {tag, " R2/R6 after window"});
    drain();
  endtask

  initial begin
    int c;
    fork
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          n_checks++;
          n_fail++;
          $display("FAIL watchdog: run did not finish, expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
      end
    join_none

    // Power-up with external reset inactive.
    power_up(1'b1, "R2");

    // R5/R6: long low on the external reset gives one four-cycle pulse.
    step();
    ext_rst_n = 1'b0;
    c = cyc;
    expect_span(c, c + 2, 1'b0, 1'b0, "R5 latency");
    expect_span(c + 3, c + 3 + L - 1, 1'b0, 1'b1, "R5 pulse");
    expect_span(c + 3 + L, c + 20, 1'b0, 1'b0, "R6 held low");
    drain();

    // R7: release is ignored.
    step();
    ext_rst_n = 1'b1;
    c = cyc;
    expect_span(c, c + 10, 1'b0, 1'b0, "R7");
    drain();

    // R8: second fall during a running pulse reloads the count.
    step();
    ext_rst_n = 1'b0;
    c = cyc;
    step();
    ext_rst_n = 1'b1;
    step();
    step();
    ext_rst_n = 1'b0;
    expect_span(c + 3, c + 9, 1'b0, 1'b1, "R8 extended");
    expect_span(c + 10, c + 16, 1'b0, 1'b0, "R8 end");
    drain();

    // R3: por stays low for a long time, then re-arm restarts the window.
    step();
    ext_rst_n = 1'b1;
    c = cyc;
    expect_span(c, c + 2 * N, 1'b0, 1'b0, "R3 saturated");
    drain();
    power_up(1'b1, "R3 rearm");

    // R6: external reset already low at power-up gives no extra pulse later.
    power_up(1'b0, "R6 held at startup");
    step();
    c = cyc;
    expect_span(c, c + 10, 1'b0, 1'b0, "R6 no late pulse");
    drain();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule